// File: doc/BRIEF.md
# Pipelined Floating-Point Product Unit

This block multiplies two 20-bit floating-point operands. It delivers the product from an output register, so the next pipeline stage, such as an adder or ALU, can use it on the following cycle. A new pair of operands can be accepted on every clock. Each word holds a two's-complement fraction and a two's-complement power of two. The fraction is multiplied through a reduced signed array that uses only the upper bits of each fraction. The exponents go through a small adder.

The raw product is normalised by removing redundant sign bits, and the exponent is adjusted to match. When the exponent would fall below the most negative code, the block does not flush the result to zero. It keeps the most negative exponent and returns an unnormalised fraction, so small amplitudes degrade gradually into fixed-point arithmetic. Products too large for the format clamp to the extreme value of the correct sign.

Top module: `fpm_mul`

## Requirements
- R1: An operand or result word carries its exponent E in bits 19:16 and its fraction M in bits 15:0. Both fields are two's complement. The value is M·2^-15·2^E, so M lies in [-1, 1) and E in [-8, +7].
- R2: Only fraction bits 15:4 of each operand take part in the product. Bits 3:0 of either operand's fraction have no effect on the result.
- R3: Outside the zero and clamp cases, the result is the exact product of the two 12-bit-truncated operands, rounded toward minus infinity. The exact product minus the result lies in [0, one result LSB), where one result LSB is 2^(E-15) for the result exponent E.
- R4: Any nonzero result whose exponent is above -8 is normalised: fraction bit 15 differs from fraction bit 14.
- R5: When the exact product lies in [-2^-9, 2^-9), the result exponent is -8 and the fraction is left unnormalised (the fixed-point region). There is no flush to zero.
- R6: A product above the largest positive value returns fraction 0x7FFF with exponent +7 (word 0x77FFF). A product below -128 returns fraction 0x8000 with exponent +7 (word 0x78000).
- R7: If the used fraction bits of either operand are all zero, the result is fraction 0 with exponent -8 (word 0x80000).
- R8: A result appears, with out_vld high, on the clock edge after the edge that samples in_vld high. Back-to-back inputs give back-to-back results.
- R9: A cycle with in_vld low leaves res unchanged and drives out_vld low on the next edge.
- R10: While reset is held, out_vld and res are zero.
- R11: A nonzero result fraction has the sign of the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand pair valid this cycle |
| op_a | input | 20 | First operand, exponent in 19:16, fraction in 15:0 |
| op_b | input | 20 | Second operand, same layout |
| out_vld | output | 1 | Registered product valid |
| res | output | 20 | Registered product, same layout |

## Verification
The bench sweeps every exponent pair against a set of fractions that covers zero, both extremes, -1 times -1, negative powers of two and unnormalised values, and then adds pseudo-random words. A wrong redundant-sign count would show up as a lost LSB, or as a -0.5 result that is left unnormalised. A design that flushed small values, or that wrapped the exponent instead of clamping at -8, would produce a wrong exponent in the fixed-point region. Wrapping instead of saturating at the top would flip the sign of large products. Pairs that differ only in the discarded low fraction bits must give identical words, and idle cycles must leave the held result alone.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

   // Outcome of the normalisation step
   typedef enum logic [1:0] {
      NC_NORMAL,
      NC_FIXED,
      NC_SATUR,
      NC_ZERO
   } norm_case_e;

   // Number of bits below the MSB that merely repeat the sign
   function automatic int redundant_signs(input logic [63:0] v, input int width);
      int  n;
      bit  stop;
      n    = 0;
      stop = 1'b0;
      for (int i = width - 2; i >= 0; i--) begin
         if (!stop && (v[i] == v[width-1])) n++;
         else stop = 1'b1;
      end
      return n;
   endfunction

endpackage

// File: rtl/fpm_mant_mul.sv
module fpm_mant_mul #(
   parameter int MANT_W = 16,
   parameter int MUL_W  = 12,
   localparam int PROD_W = 2 * MUL_W
) (
   input  logic [MANT_W-1:0]        mant_a,
   input  logic [MANT_W-1:0]        mant_b,
   output logic signed [PROD_W-1:0] prod,
   output logic                     is_zero
);

   logic signed [MUL_W-1:0] ta;
   logic signed [MUL_W-1:0] tb;

   generate
      if (MUL_W > MANT_W || MUL_W < 2) begin : g_bad_width
         $error("fpm_mant_mul: MUL_W must be in [2, MANT_W]");
      end
      if (MUL_W == MANT_W) begin : g_full
         assign ta = mant_a;
         assign tb = mant_b;
      end else begin : g_trunc
         // upper bits only, sign included
         assign ta = mant_a[MANT_W-1 -: MUL_W];
         assign tb = mant_b[MANT_W-1 -: MUL_W];
      end
   endgenerate

   assign prod    = ta * tb;
   assign is_zero = (ta == '0) || (tb == '0);

endmodule

// File: rtl/fpm_exp_add.sv
module fpm_exp_add #(
   parameter int EXP_W = 4,
   parameter int SUM_W = 11
) (
   input  logic [EXP_W-1:0]        exp_a,
   input  logic [EXP_W-1:0]        exp_b,
   output logic signed [SUM_W-1:0] esum
);

   generate
      if (SUM_W < EXP_W + 2) begin : g_bad_sum
         $error("fpm_exp_add: SUM_W too narrow");
      end
   endgenerate

   logic signed [SUM_W-1:0] ea;
   logic signed [SUM_W-1:0] eb;

   assign ea   = SUM_W'(signed'(exp_a));
   assign eb   = SUM_W'(signed'(exp_b));
   // +1 because the raw product fraction is taken with one extra sign bit
   assign esum = ea + eb + SUM_W'(1);

endmodule

// File: rtl/fpm_norm.sv
module fpm_norm
   import fpm_pkg::*;
#(
   parameter int MANT_W = 16,
   parameter int EXP_W  = 4,
   parameter int PROD_W = 24,
   parameter int SUM_W  = 11
) (
   input  logic signed [PROD_W-1:0] prod,
   input  logic signed [SUM_W-1:0]  esum,
   input  logic                     is_zero,
   output logic [MANT_W-1:0]        mant_o,
   output logic [EXP_W-1:0]         exp_o
);

   localparam int EMIN   = -(2 ** (EXP_W - 1));
   localparam int EMAX   = (2 ** (EXP_W - 1)) - 1;
   localparam int RS     = EMAX;              // deepest right shift into fixed region
   localparam int WIDE_W = PROD_W + RS;

   generate
      if (PROD_W < MANT_W || PROD_W > 63) begin : g_bad_prod
         $error("fpm_norm: PROD_W must be in [MANT_W, 63]");
      end
   endgenerate

   norm_case_e              nc;
   int                      lz;
   int                      et;
   int                      sh;
   logic signed [WIDE_W-1:0] wide;
   logic signed [WIDE_W-1:0] shv;
   logic [MANT_W-1:0]        mant_sh;

   always_comb begin
      lz = redundant_signs(64'(prod), PROD_W);
      et = int'(esum) - lz;
      sh = lz;
      if (is_zero) begin
         nc = NC_ZERO;
      end else if (et > EMAX) begin
         nc = NC_SATUR;
      end else if (et < EMIN) begin
         nc = NC_FIXED;
         sh = int'(esum) - EMIN;
      end else begin
         nc = NC_NORMAL;
      end
   end

   always_comb begin
      wide    = {prod, {RS{1'b0}}};
      shv     = (sh >= 0) ? (wide <<< sh) : (wide >>> (-sh));
      mant_sh = MANT_W'(shv >>> (WIDE_W - MANT_W));
   end

   always_comb begin
      unique case (nc)
         NC_ZERO: begin
            mant_o = '0;
            exp_o  = EXP_W'(EMIN);
         end
         NC_SATUR: begin
            mant_o = prod[PROD_W-1] ? {1'b1, {(MANT_W-1){1'b0}}}
                                    : {1'b0, {(MANT_W-1){1'b1}}};
            exp_o  = EXP_W'(EMAX);
         end
         NC_FIXED: begin
            mant_o = mant_sh;
            exp_o  = EXP_W'(EMIN);
         end
         default: begin
            mant_o = mant_sh;
            exp_o  = EXP_W'(et);
         end
      endcase
   end

   // R4
   always_comb begin
      norm_shift_chk: assert (nc != NC_NORMAL || mant_sh[MANT_W-1] != mant_sh[MANT_W-2]);
   end

endmodule

// File: rtl/fpm_mul.sv
module fpm_mul #(
   parameter int MANT_W = 16,
   parameter int EXP_W  = 4,
   parameter int MUL_W  = 12,
   localparam int OP_W  = MANT_W + EXP_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [OP_W-1:0] op_a,
   input  logic [OP_W-1:0] op_b,
   output logic            out_vld,
   output logic [OP_W-1:0] res
);

   localparam int PROD_W = 2 * MUL_W;
   localparam int SUM_W  = EXP_W + $clog2(PROD_W) + 2;
   localparam logic [EXP_W-1:0] EXP_MIN_BITS = {1'b1, {(EXP_W-1){1'b0}}};

   generate
      if (EXP_W < 2 || MANT_W < 4) begin : g_bad_fmt
         $error("fpm_mul: format too narrow");
      end
   endgenerate

   logic signed [PROD_W-1:0] prod;
   logic                     is_zero;
   logic signed [SUM_W-1:0]  esum;
   logic [MANT_W-1:0]        mant_n;
   logic [EXP_W-1:0]         exp_n;

   fpm_mant_mul #(.MANT_W(MANT_W), .MUL_W(MUL_W)) u_mant (
      .mant_a  (op_a[MANT_W-1:0]),
      .mant_b  (op_b[MANT_W-1:0]),
      .prod    (prod),
      .is_zero (is_zero)
   );

   fpm_exp_add #(.EXP_W(EXP_W), .SUM_W(SUM_W)) u_exp (
      .exp_a (op_a[OP_W-1:MANT_W]),
      .exp_b (op_b[OP_W-1:MANT_W]),
      .esum  (esum)
   );

   fpm_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W), .PROD_W(PROD_W), .SUM_W(SUM_W)) u_norm (
      .prod    (prod),
      .esum    (esum),
      .is_zero (is_zero),
      .mant_o  (mant_n),
      .exp_o   (exp_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         res     <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) res <= {exp_n, mant_n};
      end
   end

   // R8
   vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && $stable(res)));

   // R7
   zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (op_a[MANT_W-1 -: MUL_W] == '0 || op_b[MANT_W-1 -: MUL_W] == '0))
      |=> (res == {EXP_MIN_BITS, {MANT_W{1'b0}}}));

   // R11
   sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && op_a[MANT_W-1 -: MUL_W] != '0 && op_b[MANT_W-1 -: MUL_W] != '0)
      |=> (res[MANT_W-1:0] == '0 ||
           res[MANT_W-1] == $past(op_a[MANT_W-1] ^ op_b[MANT_W-1])));

   // R4
   out_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && res[OP_W-1:MANT_W] != EXP_MIN_BITS && res[MANT_W-1:0] != '0)
      |-> (res[MANT_W-1] != res[MANT_W-2]));

endmodule

// File: tb/fpm_mul_tb.sv
`timescale 1ns/1ps
module fpm_mul_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [19:0] op_a = '0;
   logic [19:0] op_b = '0;
   logic        out_vld;
   logic [19:0] res;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [31:0] lf = 32'h1234_5678;

   always #4 clk = ~clk;

   fpm_mul u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .res(res)
   );

   localparam real MAXV = (32767.0 / 32768.0) * 128.0;
   localparam real TINY = 1.0 / 512.0;

   function automatic logic [15:0] mval(input int i);
      case (i)
         0: return 16'h0000;  1: return 16'h7FFF;  2: return 16'h8000;
         3: return 16'h4000;  4: return 16'hC000;  5: return 16'h0010;
         6: return 16'hFFF0;  7: return 16'h4567;  8: return 16'hA5A0;
         9: return 16'h2000;  10: return 16'h0800; 11: return 16'hE000;
         default: return 16'h000F;
      endcase
   endfunction

   function automatic real opval(input logic [19:0] w);
      int  e;
      real m;
      e = signed'(w[19:16]);
      m = $itor(signed'(w[15:4])) / 2048.0;
      return m * (2.0 ** e);
   endfunction

   function automatic real resval(input logic [19:0] w);
      int e;
      e = signed'(w[19:16]);
      return ($itor(signed'(w[15:0])) / 32768.0) * (2.0 ** e);
   endfunction

   task automatic next_rand();
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 17);
      lf = lf ^ (lf << 5);
   endtask

   task automatic check_pair(input logic [19:0] a, input logic [19:0] b);
      real ref_v, got, lsb, d;
      int  er;
      logic [15:0] m;
      ref_v = opval(a) * opval(b);
      got   = resval(res);
      er    = signed'(res[19:16]);
      m     = res[15:0];
      checks++;
      if (!out_vld) begin
         errs++; $display("FAIL R8 out_vld got=%b exp=1", out_vld);
      end
      checks++;
      if (a[15:4] == 0 || b[15:4] == 0) begin
         if (res !== 20'h80000) begin
            errs++; $display("FAIL R7 a=%h b=%h got=%h exp=80000", a, b, res);
         end
      end else if (ref_v > MAXV) begin
         if (res !== 20'h77FFF) begin
            errs++; $display("FAIL R6 a=%h b=%h got=%h exp=77fff", a, b, res);
         end
      end else if (ref_v < -128.0) begin
         if (res !== 20'h78000) begin
            errs++; $display("FAIL R6 a=%h b=%h got=%h exp=78000", a, b, res);
         end
      end else begin
         // R1 R3: decoded value within one LSB below the exact product
         lsb = 2.0 ** (er - 15);
         d   = ref_v - got;
         if (d < 0.0 || d >= lsb) begin
            errs++; $display("FAIL R3 a=%h b=%h got=%h (%g) exp %g", a, b, res, got, ref_v);
         end
         checks++;
         if (er != -8 && m != 0 && m[15] == m[14]) begin
            errs++; $display("FAIL R4 a=%h b=%h got=%h exp normalised fraction", a, b, res);
         end
         checks++;
         if (ref_v >= -TINY && ref_v < TINY && er != -8) begin
            errs++; $display("FAIL R5 a=%h b=%h got exp=%0d exp=-8", a, b, er);
         end
         checks++;
         if (m != 0 && m[15] != (ref_v < 0.0)) begin
            errs++; $display("FAIL R11 a=%h b=%h got sign=%b exp=%b", a, b, m[15], ref_v < 0.0);
         end
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog got=timeout exp=finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic [19:0] pa, pb, a, b, r1;
      bit pend;
      pend = 1'b0;
      pa = '0; pb = '0;

      // R10: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_vld !== 1'b0 || res !== 20'h0) begin
         errs++; $display("FAIL R10 got vld=%b res=%h exp vld=0 res=00000", out_vld, res);
      end
      rst_n = 1'b1;

      // R1 R3 R4 R5 R6 R7 R8 R11: full exponent sweep, back to back
      for (int ia = 0; ia < 13; ia++)
         for (int ea = 0; ea < 16; ea++)
            for (int ib = 0; ib < 13; ib++)
               for (int eb = 0; eb < 16; eb++) begin
                  @(negedge clk);
                  if (pend) check_pair(pa, pb);
                  a = {4'(ea), mval(ia)};
                  b = {4'(eb), mval(ib)};
                  op_a = a; op_b = b; in_vld = 1'b1;
                  pa = a; pb = b; pend = 1'b1;
               end

      // pseudo-random words, back to back
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         if (pend) check_pair(pa, pb);
         next_rand(); a = lf[19:0];
         next_rand(); b = lf[19:0];
         op_a = a; op_b = b; in_vld = 1'b1;
         pa = a; pb = b; pend = 1'b1;
      end
      @(negedge clk);
      check_pair(pa, pb);
      in_vld = 1'b0;
      pend = 1'b0;

      // R2: discarded fraction bits have no effect
      for (int k = 0; k < 64; k++) begin
         next_rand(); a = {lf[19:4], 4'h0};
         next_rand(); b = {lf[19:4], 4'h0};
         @(negedge clk);
         op_a = a; op_b = b; in_vld = 1'b1;
         @(negedge clk);
         r1 = res;
         next_rand();
         op_a = {a[19:4], lf[3:0]}; op_b = {b[19:4], lf[7:4] | 4'h1};
         @(negedge clk);
         in_vld = 1'b0;
         checks++;
         if (res !== r1) begin
            errs++; $display("FAIL R2 got=%h exp=%h", res, r1);
         end
      end

      // R9: idle cycles hold the result
      @(negedge clk);
      op_a = 20'h24567; op_b = 20'h1A5A0; in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0; op_a = 20'h77FFF; op_b = 20'h77FFF;
      r1 = res;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         checks++;
         if (out_vld !== 1'b0 || res !== r1) begin
            errs++; $display("FAIL R9 got vld=%b res=%h exp vld=0 res=%h", out_vld, res, r1);
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule